// File: doc/BRIEF.md
# Pad Standby State Override

This block sits between the per-pad transmit and receive logic of a chip and the pad cells. In normal operation it is transparent: each pad's drive value and drive enable come straight from the transmit path, and the value seen at the pad goes straight back to the internal controller. When a chip-wide standby request is raised, each pad takes on a standby behaviour selected by its own 4-bit code. That behaviour can hold the pad at its last driven level, drive a fixed 0 or 1, or release the pad to high impedance. Independently of the drive, it either keeps the receive path live or replaces the returned receive value with a fixed constant.

The standby request may come from another clock domain, so it passes through a synchronizer of `SYNC_STAGES` flops before use. The synchronized request switches the override on and off for every pad on the same clock edge. The pad count is a parameter. Each pad has its own code slice and its own register for the last driven value.

Top module: `pad_stby_ovr`

## Requirements
- R1: While `rst_n` is low, every pad is in passthrough whatever `stby_req` and the codes hold, and the last-value registers clear to 0.
- R2: When the synchronized request is low, for every pad `pad_out` equals `tx_val`, `pad_oe` equals `tx_en` and `rx_core` equals `pad_in`.
- R3: A change of `stby_req` sampled at a rising clock edge reaches the override after exactly `SYNC_STAGES` rising edges, counting that edge. The outputs do not change at any earlier edge.
- R4: Code 0 (pad i uses `stby_code[4*i+3:4*i]`) drives `pad_oe`=1 with `pad_out` equal to the `tx_val` present at the edge where standby took effect. That level holds for the whole standby period whatever `tx_val` does, and `rx_core` follows `pad_in`.
- R5: Codes 1, 2, 3 and 4 drive `pad_oe`=1 with `pad_out` = 0, 0, 1, 1 and return `rx_core` = 0, 1, 0, 1 respectively, ignoring `pad_in`.
- R6: Codes 5 and 6 drive `pad_oe`=1 with `pad_out` 0 and 1 respectively, and `rx_core` follows `pad_in`.
- R7: Codes 7 and 8 set `pad_oe`=0 and `pad_out`=0, and return `rx_core` 0 and 1 respectively, ignoring `pad_in`.
- R8: Code 9 sets `pad_oe`=0 and `pad_out`=0, and `rx_core` follows `pad_in`.
- R9: Codes 10 to 15 leave the pad in passthrough during standby, exactly as in R2.
- R10: When the synchronized request falls, all pads return to passthrough at that same edge. On that edge all three outputs of every pad switch together.
- R11: Each pad's behaviour depends only on its own code slice. A code change during standby takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_req | input | 1 | Standby request, asynchronous to `clk` |
| stby_code | input | 4*PADS | Per-pad standby code, pad i in bits [4*i+3:4*i] |
| tx_val | input | PADS | Normal transmit value per pad |
| tx_en | input | PADS | Normal transmit enable per pad |
| pad_in | input | PADS | Value received at each pad |
| pad_out | output | PADS | Drive value to each pad |
| pad_oe | output | PADS | Drive enable to each pad |
| rx_core | output | PADS | Receive value returned to the internal controller |

## Verification
Each scenario loads a different set of codes across the four pads. Some mixes combine held, forced, high-impedance and ignored behaviour at once, which separates per-pad decoding from a shared decode. While standby is active, `tx_val`, `tx_en` and `pad_in` are toggled. This shows which outputs are genuinely forced and which still track their inputs, and whether the held level follows `tx_val` after entry. The request is checked one edge before and at the entry and exit edges, which pins the synchronizer latency and shows that exit restores passthrough in one step. A reset phase with the request and a high-impedance code both asserted shows that reset wins.

// File: rtl/pad_stby_pkg.sv
package pad_stby_pkg;

   localparam int CODE_W = 4;

   // Decoded per-pad standby controls
   typedef struct packed {
      logic ovr;       // override active for this code
      logic oe;        // forced drive enable
      logic use_held;  // drive the captured last value
      logic drv;       // forced drive value when not using the held value
      logic rx_force;  // replace the returned receive value
      logic rx_val;    // constant returned when rx_force is set
   } stby_ctl_t;

endpackage

// File: rtl/stby_req_sync.sv
module stby_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic req_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stby_req_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], req_i};
   end

   assign req_o = chain_q[STAGES-1];

endmodule

// File: rtl/stby_code_decode.sv
module stby_code_decode
   import pad_stby_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output stby_ctl_t         ctl_o
);

   always_comb begin
      ctl_o = '0;
      unique case (code_i)
         4'd0: begin ctl_o.ovr = 1'b1; ctl_o.oe = 1'b1; ctl_o.use_held = 1'b1; end
         4'd1: begin ctl_o.ovr = 1'b1; ctl_o.oe = 1'b1; ctl_o.rx_force = 1'b1; end
         4'd2: begin ctl_o.ovr = 1'b1; ctl_o.oe = 1'b1; ctl_o.rx_force = 1'b1; ctl_o.rx_val = 1'b1; end
         4'd3: begin ctl_o.ovr = 1'b1; ctl_o.oe = 1'b1; ctl_o.drv = 1'b1; ctl_o.rx_force = 1'b1; end
         4'd4: begin ctl_o.ovr = 1'b1; ctl_o.oe = 1'b1; ctl_o.drv = 1'b1; ctl_o.rx_force = 1'b1; ctl_o.rx_val = 1'b1; end
         4'd5: begin ctl_o.ovr = 1'b1; ctl_o.oe = 1'b1; end
         4'd6: begin ctl_o.ovr = 1'b1; ctl_o.oe = 1'b1; ctl_o.drv = 1'b1; end
         4'd7: begin ctl_o.ovr = 1'b1; ctl_o.rx_force = 1'b1; end
         4'd8: begin ctl_o.ovr = 1'b1; ctl_o.rx_force = 1'b1; ctl_o.rx_val = 1'b1; end
         4'd9: begin ctl_o.ovr = 1'b1; end
         default: ctl_o = '0;   // 10..15: request ignored
      endcase
   end

endmodule

// File: rtl/stby_pad_lane.sv
module stby_pad_lane
   import pad_stby_pkg::*;
#(
   parameter bit HELD_INIT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stby_i,
   input  stby_ctl_t ctl_i,
   input  logic      tx_val_i,
   input  logic      tx_en_i,
   input  logic      pad_in_i,
   output logic      pad_out_o,
   output logic      pad_oe_o,
   output logic      rx_o
);

   logic held_q;
   logic force_on;

   // Track the transmit value until standby takes effect, then freeze it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q <= HELD_INIT;
      else if (!stby_i) held_q <= tx_val_i;
   end

   assign force_on = stby_i & ctl_i.ovr;

   always_comb begin
      if (force_on) begin
         pad_oe_o  = ctl_i.oe;
         pad_out_o = ctl_i.oe & (ctl_i.use_held ? held_q : ctl_i.drv);
         rx_o      = ctl_i.rx_force ? ctl_i.rx_val : pad_in_i;
      end else begin
         pad_oe_o  = tx_en_i;
         pad_out_o = tx_val_i;
         rx_o      = pad_in_i;
      end
   end

endmodule

// File: rtl/pad_stby_ovr.sv
module pad_stby_ovr
   import pad_stby_pkg::*;
#(
   parameter int PADS        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   stby_req,
   input  logic [CODE_W*PADS-1:0] stby_code,
   input  logic [PADS-1:0]        tx_val,
   input  logic [PADS-1:0]        tx_en,
   input  logic [PADS-1:0]        pad_in,
   output logic [PADS-1:0]        pad_out,
   output logic [PADS-1:0]        pad_oe,
   output logic [PADS-1:0]        rx_core
);

   generate
      if (PADS < 1) begin : g_bad_pads
         $error("pad_stby_ovr: PADS must be at least 1");
      end
      if (CODE_W != 4) begin : g_bad_code
         $error("pad_stby_ovr: standby code must be 4 bits");
      end
   endgenerate

   logic stby_s;

   stby_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (stby_req),
      .req_o (stby_s)
   );

   for (genvar i = 0; i < PADS; i++) begin : g_pad
      logic [CODE_W-1:0] lane_code;
      stby_ctl_t         lane_ctl;

      assign lane_code = stby_code[i*CODE_W +: CODE_W];

      stby_code_decode u_dec (
         .code_i (lane_code),
         .ctl_o  (lane_ctl)
      );

      stby_pad_lane u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .stby_i    (stby_s),
         .ctl_i     (lane_ctl),
         .tx_val_i  (tx_val[i]),
         .tx_en_i   (tx_en[i]),
         .pad_in_i  (pad_in[i]),
         .pad_out_o (pad_out[i]),
         .pad_oe_o  (pad_oe[i]),
         .rx_o      (rx_core[i])
      );

      assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !stby_s |-> (pad_out[i] == tx_val[i] && pad_oe[i] == tx_en[i] && rx_core[i] == pad_in[i]));

      assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (stby_s && $past(stby_s) && lane_code == 4'd0 && $past(lane_code) == 4'd0)
         |-> (pad_oe[i] && pad_out[i] == $past(pad_out[i])));

      assert_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (stby_s && lane_code >= 4'd1 && lane_code <= 4'd4)
         |-> (pad_oe[i] && rx_core[i] == !lane_code[0] && pad_out[i] == (lane_code >= 4'd3)));

      assert_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (stby_s && (lane_code == 4'd7 || lane_code == 4'd8))
         |-> (!pad_oe[i] && !pad_out[i] && rx_core[i] == (lane_code == 4'd8)));

      assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (stby_s && lane_code >= 4'd10)
         |-> (pad_out[i] == tx_val[i] && pad_oe[i] == tx_en[i] && rx_core[i] == pad_in[i]));
   end

endmodule

// File: tb/test_pad_stby_ovr.sv
module test_pad_stby_ovr;

   localparam int CLK_PERIOD = 10;
   localparam int PADS       = 4;
   localparam int SYNC       = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              stby_req = 1'b0;
   logic [4*PADS-1:0] stby_code = '0;
   logic [PADS-1:0]   tx_val = '0;
   logic [PADS-1:0]   tx_en = '0;
   logic [PADS-1:0]   pad_in = '0;
   logic [PADS-1:0]   pad_out;
   logic [PADS-1:0]   pad_oe;
   logic [PADS-1:0]   rx_core;

   logic [PADS-1:0]   held_exp = '0;
   bit                active_exp = 1'b0;
   bit                done = 1'b0;
   int                n_chk = 0;
   int                n_fail = 0;

   pad_stby_ovr #(.PADS(PADS), .SYNC_STAGES(SYNC)) i_pad_stby_ovr (
      .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .stby_code(stby_code),
      .tx_val(tx_val), .tx_en(tx_en), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .rx_core(rx_core)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Expected outputs of one pad from the requirement table
   function automatic void model(input logic [3:0] c, input bit act, input logic tx,
                                 input logic en, input logic pin, input logic held,
                                 output logic eo, output logic eoe, output logic erx);
      eo = tx; eoe = en; erx = pin;
      if (act) begin
         if (c == 4'd0) begin eoe = 1; eo = held; end
         else if (c <= 4'd4) begin eoe = 1; eo = (c >= 4'd3); erx = (c == 4'd2 || c == 4'd4); end
         else if (c <= 4'd6) begin eoe = 1; eo = (c == 4'd6); end
         else if (c <= 4'd8) begin eoe = 0; eo = 0; erx = (c == 4'd8); end
         else if (c == 4'd9) begin eoe = 0; eo = 0; end
      end
   endfunction

   task automatic check_pads(input string req);
      for (int i = 0; i < PADS; i++) begin
         logic eo, eoe, erx;
         model(stby_code[i*4 +: 4], active_exp, tx_val[i], tx_en[i], pad_in[i], held_exp[i],
               eo, eoe, erx);
         n_chk++;
         if (pad_out[i] !== eo || pad_oe[i] !== eoe || rx_core[i] !== erx) begin
            n_fail++;
            $display("FAIL %s pad %0d code %0d: out/oe/rx = %b%b%b expected %b%b%b",
                     req, i, stby_code[i*4 +: 4], pad_out[i], pad_oe[i], rx_core[i], eo, eoe, erx);
         end
      end
   endtask

   task automatic set_codes(input logic [3:0] c0, input logic [3:0] c1,
                            input logic [3:0] c2, input logic [3:0] c3);
      stby_code = {c3, c2, c1, c0};
   endtask

   // R3: entry takes effect at the SYNC-th edge, not earlier
   task automatic enter_stby();
      stby_req = 1'b1;
      step(SYNC - 1);
      active_exp = 1'b0;
      check_pads("R3");
      step(1);
      held_exp   = tx_val;
      active_exp = 1'b1;
      check_pads("R3");
   endtask

   // R3/R10: exit takes effect at the SYNC-th edge, all outputs together
   task automatic leave_stby();
      stby_req = 1'b0;
      step(SYNC - 1);
      check_pads("R3");
      step(1);
      active_exp = 1'b0;
      check_pads("R10");
   endtask

   task automatic t_reset();
      stby_req = 1'b1;
      set_codes(4'd7, 4'd7, 4'd7, 4'd7);
      tx_val = 4'b1010; tx_en = 4'b1111; pad_in = 4'b0110;
      step(4);
      active_exp = 1'b0;
      check_pads("R1");
      stby_req = 1'b0;
      step(SYNC + 1);
      rst_n = 1'b1;
      step(1);
      check_pads("R1");
   endtask

   task automatic t_passthrough();
      set_codes(4'd1, 4'd7, 4'd0, 4'd9);
      tx_val = 4'b0101; tx_en = 4'b0011; pad_in = 4'b1001; step(1); check_pads("R2");
      tx_val = 4'b1111; tx_en = 4'b1100; pad_in = 4'b0000; step(1); check_pads("R2");
      tx_val = 4'b0000; tx_en = 4'b0000; pad_in = 4'b1111; step(1); check_pads("R2");
   endtask

   task automatic t_hold_last();
      set_codes(4'd0, 4'd0, 4'd0, 4'd0);
      tx_val = 4'b1011; tx_en = 4'b0000; pad_in = 4'b0101;
      enter_stby();
      tx_val = 4'b0100; pad_in = 4'b1010; step(2); check_pads("R4");
      tx_val = 4'b1111; tx_en = 4'b1111;  step(3); check_pads("R4");
      leave_stby();
   endtask

   task automatic t_forced_drive();
      set_codes(4'd1, 4'd2, 4'd3, 4'd4);
      tx_val = 4'b0110; tx_en = 4'b0000; pad_in = 4'b0000;
      enter_stby();
      pad_in = 4'b1111; tx_val = 4'b1001; step(1); check_pads("R5");
      set_codes(4'd5, 4'd6, 4'd5, 4'd6);
      step(1); check_pads("R6");
      pad_in = 4'b0011; tx_en = 4'b1111; step(1); check_pads("R6");
      leave_stby();
   endtask

   task automatic t_high_z();
      set_codes(4'd7, 4'd8, 4'd9, 4'd7);
      tx_val = 4'b1111; tx_en = 4'b1111; pad_in = 4'b1010;
      enter_stby();
      check_pads("R7");
      pad_in = 4'b0101; step(1); check_pads("R7");
      set_codes(4'd9, 4'd9, 4'd8, 4'd9);
      pad_in = 4'b1100; step(1); check_pads("R8");
      leave_stby();
   endtask

   task automatic t_ignored();
      set_codes(4'd10, 4'd12, 4'd14, 4'd15);
      tx_val = 4'b0011; tx_en = 4'b0101; pad_in = 4'b1110;
      enter_stby();
      tx_val = 4'b1100; tx_en = 4'b1010; pad_in = 4'b0001; step(1); check_pads("R9");
      set_codes(4'd11, 4'd13, 4'd15, 4'd10);
      tx_val = 4'b0110; step(1); check_pads("R9");
      leave_stby();
   endtask

   task automatic t_mixed();
      set_codes(4'd0, 4'd3, 4'd8, 4'd15);
      tx_val = 4'b1001; tx_en = 4'b0110; pad_in = 4'b0011;
      enter_stby();
      check_pads("R11");
      tx_val = 4'b0110; tx_en = 4'b1001; pad_in = 4'b1100; step(1); check_pads("R11");
      set_codes(4'd0, 4'd15, 4'd2, 4'd7);
      #1 check_pads("R11");
      leave_stby();
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_passthrough();
      t_hold_last();
      t_forced_drive();
      t_high_z();
      t_ignored();
      t_mixed();
      step(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule